// File: doc/BRIEF.md
# Programmable Bit-Serial CRC Generator and Checker

This block computes a cyclic redundancy check over a packet that arrives one bit per clock, most significant bit of each byte first. Every incoming bit carries a two-bit kind tag saying whether it belongs to the preamble, the address, the payload or the trailing CRC field. The generator polynomial, the CRC width (8, 16 or 24 bits), the starting value of the register stages, and whether the address bits take part are all set at runtime. They are latched when a packet begins.

In transmit mode, the block outputs the finished CRC on `tx_bit` while the sender presents CRC-field slots, most significant bit first. In receive mode, it compares the incoming CRC field against the computed value. After the last CRC bit it raises exactly one single-cycle event, either pass or fail. The received field is kept in `rx_crc` for software whatever the outcome. The computed register itself is not exposed on any port.

Top module: `serial_crc_engine`

## Requirements
- R1: After reset, `crc_ok`, `crc_err`, `tx_bit` and `rx_crc` are all zero.
- R2: A cycle with `pkt_start` high loads the register stages with `cfg_seed` masked to the width n, and latches the polynomial, width, address-skip and mode settings. Width code `cfg_len` = 1 gives n = 8, 2 gives n = 16, and 0 or 3 give n = 24. Stages at or above n always stay zero.
- R3: Each covered bit b updates the register as follows: with f = stage[n-1] xor b, the register shifts left by one, and if f is 1 the latched polynomial is xored in. Polynomial bit k is the coefficient of x^k, with x^n implied. With polynomial 0x1021, seed 0 and n = 16, the ASCII string "123456789" yields 0x31C3. With polynomial 0x07, seed 0 and n = 8, it yields 0xF4.
- R4: Bits of kind 0 (preamble) never change the register.
- R5: Bits of kind 1 (address) are covered only when the address-skip setting latched at start is 0. Bits of kind 2 (payload) are always covered.
- R6: In transmit mode, during the k-th CRC-field slot (kind 3, k counted from 0), `tx_bit` equals register bit n-1-k. The register is frozen for the whole CRC field.
- R7: In receive mode, if all n CRC-field bits match the register, `crc_ok` is high for exactly the one cycle after the last CRC bit.
- R8: In receive mode, if any CRC-field bit differs, `crc_err` is high instead, for exactly one cycle. The two events are never high together.
- R9: In receive mode, at the last CRC bit `rx_crc` takes the n received bits, first-received bit as the MSB, whether the check passes or fails. It does not change in any cycle that carries no CRC-field bit.
- R10: CRC-field bits beyond the n-th are ignored. Transmit-mode packets raise no event.
- R11: Configuration inputs that change after `pkt_start` do not affect the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_poly | input | 24 | Polynomial coefficients, bit k = x^k |
| cfg_seed | input | 24 | Starting value of the register stages |
| cfg_len | input | 2 | Width code: 1 = 8, 2 = 16, otherwise 24 bits |
| cfg_skip_addr | input | 1 | 1 leaves address bits out of the CRC |
| cfg_tx | input | 1 | 1 = transmit mode, 0 = receive mode |
| pkt_start | input | 1 | Begins a packet; the bit slot in this cycle is dropped |
| bit_valid | input | 1 | A packet bit is present this cycle |
| bit_kind | input | 2 | 0 preamble, 1 address, 2 payload, 3 CRC field |
| bit_data | input | 1 | Packet bit value |
| tx_bit | output | 1 | Current outgoing CRC bit (transmit) |
| rx_crc | output | 24 | Last received CRC field |
| crc_ok | output | 1 | One-cycle pass event |
| crc_err | output | 1 | One-cycle fail event |

## Verification
The checker assumes that `bit_kind` is valid whenever `bit_valid` is high. It also assumes that each packet begins with `pkt_start`, and that the sender keeps the field order of preamble, address, payload, then CRC. The event properties count on a CRC bit being presented only in the cycle after a matching slot. The bench drives every bit through one task at the falling edge, always starts packets with `pkt_start`, and keeps the kinds in order. It violates the order only on purpose, when it appends surplus CRC slots to test that they are ignored.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int unsigned CRC_MAX_W = 24;
    localparam int unsigned CRC_IDX_W = 5;

    typedef enum logic [1:0] {
        KIND_PRE  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_BODY = 2'd2,
        KIND_CRC  = 2'd3
    } bit_kind_e;

    function automatic logic [CRC_IDX_W-1:0] width_of(input logic [1:0] code);
        case (code)
            2'd1:    return CRC_IDX_W'(8);
            2'd2:    return CRC_IDX_W'(16);
            default: return CRC_IDX_W'(24);
        endcase
    endfunction
endpackage

// File: rtl/crc_shift_core.sv
module crc_shift_core #(
    parameter int unsigned W   = crc_pkg::CRC_MAX_W,
    parameter int unsigned IDX = crc_pkg::CRC_IDX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pkt_start,
    input  logic [W-1:0]   cfg_poly,
    input  logic [W-1:0]   cfg_seed,
    input  logic [1:0]     cfg_len,
    input  logic           cfg_skip_addr,
    input  logic           cfg_tx,
    input  logic           bit_valid,
    input  logic [1:0]     bit_kind,
    input  logic           bit_data,
    output logic [W-1:0]   crc_reg,
    output logic [IDX-1:0] width,
    output logic           tx_mode
);
    import crc_pkg::*;

    typedef struct packed {
        logic [W-1:0]   crc;
        logic [W-1:0]   poly;
        logic [IDX-1:0] wid;
        logic           skip;
        logic           tx;
    } core_t;

    core_t q, d;
    logic [W-1:0]   mask_new, mask_cur;
    logic [IDX-1:0] wid_new;
    logic [IDX-1:0] top_pos;
    logic           covered, fb;

    always_comb begin
        wid_new = width_of(cfg_len);
        for (int i = 0; i < W; i++) begin
            mask_new[i] = (i < int'(wid_new));
            mask_cur[i] = (i < int'(q.wid));
        end
        top_pos = q.wid - IDX'(1);
        covered = bit_valid && ((bit_kind == KIND_BODY) ||
                                (bit_kind == KIND_ADDR && !q.skip));
        fb      = q.crc[top_pos] ^ bit_data;

        d = q;
        if (pkt_start) begin
            d.crc  = cfg_seed & mask_new;
            d.poly = cfg_poly & mask_new;
            d.wid  = wid_new;
            d.skip = cfg_skip_addr;
            d.tx   = cfg_tx;
        end else if (covered) begin
            d.crc = ((q.crc << 1) ^ (fb ? q.poly : '0)) & mask_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.wid  <= IDX'(W);
        end else begin
            q <= d;
        end
    end

    assign crc_reg = q.crc;
    assign width   = q.wid;
    assign tx_mode = q.tx;
endmodule

// File: rtl/crc_field_check.sv
module crc_field_check #(
    parameter int unsigned W   = crc_pkg::CRC_MAX_W,
    parameter int unsigned IDX = crc_pkg::CRC_IDX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pkt_start,
    input  logic           bit_valid,
    input  logic [1:0]     bit_kind,
    input  logic           bit_data,
    input  logic [W-1:0]   crc_reg,
    input  logic [IDX-1:0] width,
    input  logic           tx_mode,
    output logic           tx_bit,
    output logic [W-1:0]   rx_crc,
    output logic           crc_ok,
    output logic           crc_err
);
    import crc_pkg::*;

    typedef struct packed {
        logic [IDX-1:0] idx;
        logic           done;
        logic           miss;
        logic [W-1:0]   shadow;
        logic [W-1:0]   rx;
        logic           ok;
        logic           err;
    } chk_t;

    chk_t q, d;
    logic [W-1:0]   mask;
    logic [IDX-1:0] pos;
    logic           expect_bit, field_bit, last_bit, miss_n;
    logic [W-1:0]   shadow_n;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < int'(width));
        end
        pos        = width - IDX'(1) - q.idx;
        expect_bit = q.done ? 1'b0 : crc_reg[pos];
        field_bit  = bit_valid && (bit_kind == KIND_CRC) && !q.done && !pkt_start;
        last_bit   = (q.idx == width - IDX'(1));
        shadow_n   = ((q.shadow << 1) | W'(bit_data)) & mask;
        miss_n     = q.miss | (bit_data != expect_bit);

        d     = q;
        d.ok  = 1'b0;
        d.err = 1'b0;
        if (pkt_start) begin
            d.idx    = '0;
            d.done   = 1'b0;
            d.miss   = 1'b0;
            d.shadow = '0;
        end else if (field_bit) begin
            d.idx    = q.idx + IDX'(1);
            d.shadow = shadow_n;
            d.miss   = miss_n;
            if (last_bit) begin
                d.done = 1'b1;
                if (!tx_mode) begin
                    d.rx  = shadow_n;
                    d.ok  = !miss_n;
                    d.err = miss_n;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.done <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_bit  = expect_bit;
    assign rx_crc  = q.rx;
    assign crc_ok  = q.ok;
    assign crc_err = q.err;
endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine #(
    parameter int unsigned W   = crc_pkg::CRC_MAX_W,
    parameter int unsigned IDX = crc_pkg::CRC_IDX_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cfg_poly,
    input  logic [W-1:0] cfg_seed,
    input  logic [1:0]   cfg_len,
    input  logic         cfg_skip_addr,
    input  logic         cfg_tx,
    input  logic         pkt_start,
    input  logic         bit_valid,
    input  logic [1:0]   bit_kind,
    input  logic         bit_data,
    output logic         tx_bit,
    output logic [W-1:0] rx_crc,
    output logic         crc_ok,
    output logic         crc_err
);
    logic [W-1:0]   crc_reg;
    logic [IDX-1:0] width;
    logic           tx_mode;

    crc_shift_core #(.W(W), .IDX(IDX)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_start     (pkt_start),
        .cfg_poly      (cfg_poly),
        .cfg_seed      (cfg_seed),
        .cfg_len       (cfg_len),
        .cfg_skip_addr (cfg_skip_addr),
        .cfg_tx        (cfg_tx),
        .bit_valid     (bit_valid),
        .bit_kind      (bit_kind),
        .bit_data      (bit_data),
        .crc_reg       (crc_reg),
        .width         (width),
        .tx_mode       (tx_mode)
    );

    crc_field_check #(.W(W), .IDX(IDX)) u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .bit_valid (bit_valid),
        .bit_kind  (bit_kind),
        .bit_data  (bit_data),
        .crc_reg   (crc_reg),
        .width     (width),
        .tx_mode   (tx_mode),
        .tx_bit    (tx_bit),
        .rx_crc    (rx_crc),
        .crc_ok    (crc_ok),
        .crc_err   (crc_err)
    );
endmodule

// File: rtl/serial_crc_engine_checks.sv
module serial_crc_engine_checks #(
    parameter int unsigned W   = crc_pkg::CRC_MAX_W,
    parameter int unsigned IDX = crc_pkg::CRC_IDX_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pkt_start,
    input logic           bit_valid,
    input logic [1:0]     bit_kind,
    input logic [W-1:0]   crc_reg,
    input logic [IDX-1:0] width,
    input logic           tx_mode,
    input logic [W-1:0]   rx_crc,
    input logic           crc_ok,
    input logic           crc_err
);
    logic [W-1:0] mask;
    always_comb begin
        for (int i = 0; i < W; i++) mask[i] = (i < int'(width));
    end

    AST_STAGES_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_reg & ~mask) == '0); // R2
    AST_PREAMBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_kind == 2'd0 && !pkt_start) |=> $stable(crc_reg)); // R4
    AST_OK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |=> !crc_ok); // R7
    AST_EVENT_FOLLOWS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok || crc_err) |-> $past(bit_valid && bit_kind == 2'd3 && !pkt_start)); // R7
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> !crc_err); // R8
    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok && crc_err)); // R8
    AST_RXCRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && bit_kind == 2'd3) |=> $stable(rx_crc)); // R9
    AST_TX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && !pkt_start) |=> (!crc_ok && !crc_err)); // R10
endmodule

bind serial_crc_engine serial_crc_engine_checks #(.W(W), .IDX(IDX)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_start (pkt_start),
    .bit_valid (bit_valid),
    .bit_kind  (bit_kind),
    .crc_reg   (crc_reg),
    .width     (width),
    .tx_mode   (tx_mode),
    .rx_crc    (rx_crc),
    .crc_ok    (crc_ok),
    .crc_err   (crc_err)
);

// File: tb/serial_crc_engine_test.sv
`timescale 1ns/1ps
module serial_crc_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cfg_poly = '0, cfg_seed = '0;
    logic [1:0]  cfg_len = 2'd2;
    logic        cfg_skip_addr = 1'b0, cfg_tx = 1'b0;
    logic        pkt_start = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
    logic [1:0]  bit_kind = 2'd0;
    logic        tx_bit, crc_ok, crc_err;
    logic [23:0] rx_crc;

    int n_checks = 0, n_fail = 0;
    logic [23:0] m_crc, m_poly, m_mask;
    int          m_w;
    logic        m_skip, last_tx;

    always #5 clk = ~clk;

    serial_crc_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_poly(cfg_poly), .cfg_seed(cfg_seed),
        .cfg_len(cfg_len), .cfg_skip_addr(cfg_skip_addr), .cfg_tx(cfg_tx),
        .pkt_start(pkt_start), .bit_valid(bit_valid), .bit_kind(bit_kind),
        .bit_data(bit_data), .tx_bit(tx_bit), .rx_crc(rx_crc),
        .crc_ok(crc_ok), .crc_err(crc_err)
    );

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic start(input logic [23:0] poly, input logic [23:0] seed,
                         input logic [1:0] len, input logic skip, input logic tx);
        @(negedge clk);
        cfg_poly = poly; cfg_seed = seed; cfg_len = len;
        cfg_skip_addr = skip; cfg_tx = tx;
        pkt_start = 1'b1; bit_valid = 1'b0;
        m_w    = (len == 2'd1) ? 8 : (len == 2'd2) ? 16 : 24;
        m_mask = 24'hFFFFFF >> (24 - m_w);
        m_poly = poly & m_mask;
        m_crc  = seed & m_mask;
        m_skip = skip;
    endtask

    task automatic put(input logic [1:0] k, input logic b);
        logic fb;
        @(negedge clk);
        pkt_start = 1'b0; bit_valid = 1'b1; bit_kind = k; bit_data = b;
        #1 last_tx = tx_bit;
        if (k == 2'd2 || (k == 2'd1 && !m_skip)) begin
            fb    = m_crc[m_w-1] ^ b;
            m_crc = ((m_crc << 1) ^ (fb ? m_poly : 24'd0)) & m_mask;
        end
    endtask

    task automatic put_byte(input logic [1:0] k, input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put(k, v[i]);
    endtask

    task automatic put_digits();
        for (int i = 1; i <= 9; i++) put_byte(2'd2, 8'h30 + 8'(i));
    endtask

    task automatic tx_field(output logic [23:0] got);
        got = '0;
        for (int i = 0; i < m_w; i++) begin
            put(2'd3, 1'b0);
            got = (got << 1) | 24'(last_tx);
        end
    endtask

    task automatic rx_field(input logic [23:0] v);
        for (int i = m_w - 1; i >= 0; i--) put(2'd3, v[i]);
    endtask

    task automatic events_after(input logic exp_ok, input logic exp_err, input string req);
        @(negedge clk);
        bit_valid = 1'b0;
        #1;
        check(crc_ok == exp_ok && crc_err == exp_err, req, {22'd0, crc_ok, crc_err}, {22'd0, exp_ok, exp_err});
        @(negedge clk);
        #1;
        check(!crc_ok && !crc_err, {req, " one-cycle"}, {22'd0, crc_ok, crc_err}, 24'd0);
    endtask

    task automatic t_reset();
        #1;
        check(!crc_ok && !crc_err && !tx_bit && rx_crc == 0, "R1 reset", rx_crc, 24'd0);
    endtask

    task automatic t_tx_crc16();
        logic [23:0] got;
        start(24'h001021, 24'h0, 2'd2, 1'b0, 1'b1);
        put_byte(2'd0, 8'hAA); // R4: preamble bits ignored
        put_digits();
        tx_field(got);
        check(got == 24'h31C3, "R3 R4 R6 crc16 tx", got, 24'h31C3);
        events_after(1'b0, 1'b0, "R10 tx no event");
    endtask

    task automatic t_tx_crc8();
        logic [23:0] got;
        start(24'hFFFF07, 24'h0, 2'd1, 1'b0, 1'b1);
        put_digits();
        tx_field(got);
        check(got == 24'hF4, "R2 R3 crc8 tx", got, 24'hF4);
    endtask

    task automatic t_seed_only();
        logic [23:0] got;
        start(24'h001021, 24'hABCDEF, 2'd2, 1'b0, 1'b1);
        tx_field(got);
        check(got == 24'h00CDEF, "R2 seed masked", got, 24'h00CDEF);
    endtask

    task automatic rx_packet(input logic skip, input logic [31:0] addr, input logic corrupt,
                             output logic [23:0] sent);
        start(24'h00065B, 24'h555555, 2'd3, skip, 1'b0);
        put_byte(2'd0, 8'h55);
        for (int i = 31; i >= 0; i--) put(2'd1, addr[i]);
        put_byte(2'd2, 8'h3C); put_byte(2'd2, 8'hA5); put_byte(2'd2, 8'h0F);
        sent = m_crc ^ (corrupt ? 24'h000100 : 24'h0);
        rx_field(sent);
    endtask

    task automatic t_rx_ok();
        logic [23:0] s;
        rx_packet(1'b0, 32'h8E89BED6, 1'b0, s);
        events_after(1'b1, 1'b0, "R7 rx ok pulse");
        check(rx_crc == s, "R9 rx capture ok", rx_crc, s);
    endtask

    task automatic t_rx_err();
        logic [23:0] s;
        rx_packet(1'b0, 32'h8E89BED6, 1'b1, s);
        events_after(1'b0, 1'b1, "R8 rx err pulse");
        check(rx_crc == s, "R9 rx capture on error", rx_crc, s);
    endtask

    task automatic t_skip_addr();
        logic [23:0] s1, s2;
        rx_packet(1'b1, 32'h12345678, 1'b0, s1);
        events_after(1'b1, 1'b0, "R5 skip addr ok");
        rx_packet(1'b1, 32'hCAFEF00D, 1'b0, s2);
        events_after(1'b1, 1'b0, "R5 skip addr ok 2");
        check(s1 == s2, "R5 addr not covered", s2, s1);
        rx_packet(1'b0, 32'hCAFEF00D, 1'b0, s2);
        events_after(1'b1, 1'b0, "R5 addr covered ok");
        check(s1 != s2, "R5 addr covered differs", s2, s1);
    endtask

    task automatic t_extra_bits();
        logic [23:0] s;
        rx_packet(1'b0, 32'h0BADBEEF, 1'b0, s);
        for (int i = 0; i < 8; i++) put(2'd3, 1'b1);
        @(negedge clk);
        bit_valid = 1'b0;
        #1;
        check(!crc_ok && !crc_err, "R10 extra crc bits no event", {22'd0, crc_ok, crc_err}, 24'd0);
        check(rx_crc == s, "R10 extra crc bits ignored", rx_crc, s);
    endtask

    task automatic t_cfg_latch();
        logic [23:0] got;
        start(24'h001021, 24'h0, 2'd2, 1'b0, 1'b1);
        @(negedge clk);
        pkt_start = 1'b0;
        cfg_poly = 24'h008005; cfg_seed = 24'hFFFFFF; cfg_len = 2'd3; cfg_tx = 1'b0;
        put_digits();
        tx_field(got);
        check(got == 24'h31C3, "R11 config latched", got, 24'h31C3);
        events_after(1'b0, 1'b0, "R11 mode latched");
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_tx_crc16();
        t_tx_crc8();
        t_seed_only();
        t_rx_ok();
        t_rx_err();
        t_skip_addr();
        t_extra_bits();
        t_cfg_latch();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule